// File: doc/BRIEF.md
# Coherence Command Ordering Scheduler

This block sits on the system side of a processor's coherence pins. It takes three request streams and drives them onto two cycle-exact buses so that the processor updates its cache state in the same order the system serialized the requests. The three streams are snoop probes, fill-class data commands (line fills, and change-to-dirty grants that carry only virtual data beats), and victim-buffer release commands. The probe bus carries a four-cycle address phase. The data bus carries quadword beats, or a single release cycle.

Each stream enters through a valid/ready pair and is held in a one-entry slot. Every accepted request is stamped with a wrapping sequence tag. The oldest pending request is always the next to be issued, and it is issued only when the pairing rule against the traffic ahead of it allows. A data command of either class waits until every issued probe has been answered on the response strobe. A probe that follows a fill starts early enough that the second data beat lands no later than the probe's last address cycle. A probe that follows a release starts strictly after the release cycle.

A bus-side monitor compares 64-byte block addresses and raises a sticky flag if the buses ever show a pairing that breaks these rules.

Top module: `coh_order_sched`

## Requirements
- R1: A probe occupies exactly four consecutive probe-bus cycles, with `pbus_cycle` counting 0, 1, 2, 3 (A0 to A3) and `pbus_addr` held constant.
- R2: Data-bus encoding. A fill shows `dbus_kind`=1 for FILL_BEATS beats with `dbus_virtual`=0. A change-to-dirty grant shows `dbus_kind`=2 for CTD_BEATS beats with `dbus_virtual`=1. A release shows `dbus_kind`=3 for one cycle. In every case `dbus_beat` counts from 0.
- R3: Requests are issued in the order they were accepted, and no request overtakes an older one. Requests accepted on the same edge rank as probe first, then fill stream, then release stream.
- R4: A probe that follows a probe begins its A0 in the cycle right after the earlier probe's A3.
- R5: A fill, grant or release that follows a probe shows its first beat in the cycle right after the edge at which the last outstanding `prb_resp` is sampled, and never earlier.
- R6: A probe that follows a fill or grant begins A0 in the cycle after that command's beat 0, so its D1 falls at or before A3.
- R7: A probe that follows a release begins A0 in the cycle after the release cycle.
- R8: A data command that follows a data command shows beat 0 in the cycle after the earlier command's last beat.
- R9: A stream's ready is high while its slot is empty or being issued. On an idle scheduler, a request accepted at one edge is on its bus in the next cycle.
- R10: `order_err` is low out of reset, stays low under any traffic this scheduler produces, and once set stays set until reset.
- R11: At most MAX_PRB_OUT probes await a response. A further probe waits for a response before it issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prb_req_valid | input | 1 | Probe request valid |
| prb_req_ready | output | 1 | Probe slot can accept |
| prb_req_addr | input | ADDR_W | Probe byte address |
| fil_req_valid | input | 1 | Fill-class request valid |
| fil_req_ready | output | 1 | Fill slot can accept |
| fil_req_addr | input | ADDR_W | Fill byte address |
| fil_req_ctd | input | 1 | 1: change-to-dirty grant, 0: fill |
| rel_req_valid | input | 1 | Release request valid |
| rel_req_ready | output | 1 | Release slot can accept |
| rel_req_addr | input | ADDR_W | Release byte address |
| pbus_valid | output | 1 | Probe bus active |
| pbus_cycle | output | 2 | Address cycle index A0..A3 |
| pbus_addr | output | ADDR_W | Probe address on the bus |
| prb_resp | input | 1 | One-cycle probe response strobe |
| dbus_valid | output | 1 | Data bus active |
| dbus_kind | output | 2 | 1 fill, 2 grant, 3 release |
| dbus_beat | output | BEAT_W | Beat index |
| dbus_virtual | output | 1 | Beat carries no real data |
| dbus_addr | output | ADDR_W | Address of the data command |
| order_err | output | 1 | Sticky ordering-violation flag |

## Verification
The probe bus and the data bus run side by side, so one command's address phase and another's data beats often share cycles. That happens after a fill, where the next probe's A0 lands on D1, and after a release, where the probe starts one cycle later. The bench produces these overlaps by accepting every ordered pair of the four command kinds on consecutive edges, with the second command in the same block or in another block, under two response delays. It judges each run by the exact start cycle of the second command, the total number of data beats and the flag. It also accepts all three streams on one edge to test the tie ranking, and sends a third probe while two are still unanswered.

// File: rtl/coh_pkg.sv
package coh_pkg;

    localparam int TAG_W     = 4;
    localparam int N_STREAMS = 3;
    localparam int S_PRB     = 0;
    localparam int S_FIL     = 1;
    localparam int S_REL     = 2;

    typedef logic [TAG_W-1:0] tag_t;

    typedef enum logic [1:0] {
        K_PROBE = 2'd0,
        K_FILL  = 2'd1,
        K_CTD   = 2'd2,
        K_REL   = 2'd3
    } cmd_kind_e;

    // a is older than b under wrapping arithmetic (few entries in flight)
    function automatic logic tag_older(input tag_t a, input tag_t b);
        tag_t d;
        d = a - b;
        return d[TAG_W-1];
    endfunction

endpackage

// File: rtl/coh_req_slot.sv
module coh_req_slot
    import coh_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_ctd,
    input  tag_t              in_tag,
    input  logic              take,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_ctd,
    output tag_t              out_tag
);

    assign in_ready = !out_valid || take;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_ctd   <= 1'b0;
            out_tag   <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_addr  <= in_addr;
            out_ctd   <= in_ctd;
            out_tag   <= in_tag;
        end else if (take) begin
            out_valid <= 1'b0;
        end
    end

    AST_SLOT_KEEPS_PLACE: assert property (@(posedge clk) disable iff (rst) (out_valid && !take) |=> (out_valid && $stable(out_tag) && $stable(out_addr))); // R3

endmodule

// File: rtl/coh_probe_engine.sv
module coh_probe_engine #(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              free,
    output logic              bus_valid,
    output logic [1:0]        bus_cycle,
    output logic [ADDR_W-1:0] bus_addr
);

    localparam logic [1:0] LAST_CYC = 2'd3;

    logic active;

    assign free      = !active || (bus_cycle == LAST_CYC);
    assign bus_valid = active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            bus_cycle <= 2'd0;
            bus_addr  <= '0;
        end else if (start) begin
            active    <= 1'b1;
            bus_cycle <= 2'd0;
            bus_addr  <= start_addr;
        end else if (active) begin
            if (bus_cycle == LAST_CYC) active <= 1'b0;
            else                       bus_cycle <= bus_cycle + 2'd1;
        end
    end

    AST_PRB_PHASE_STEP: assert property (@(posedge clk) disable iff (rst) (active && bus_cycle != LAST_CYC) |=> (active && bus_cycle == $past(bus_cycle) + 2'd1 && $stable(bus_addr))); // R1
    AST_PRB_START_A0: assert property (@(posedge clk) disable iff (rst) start |=> (active && bus_cycle == 2'd0)); // R4

endmodule

// File: rtl/coh_data_engine.sv
module coh_data_engine
    import coh_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int FILL_BEATS = 8,
    parameter int CTD_BEATS  = 2,
    parameter int BEAT_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cmd_kind_e         start_kind,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              free,
    output logic              bus_valid,
    output cmd_kind_e         bus_kind,
    output logic [BEAT_W-1:0] bus_beat,
    output logic              bus_virtual,
    output logic [ADDR_W-1:0] bus_addr
);

    logic              active;
    logic [BEAT_W-1:0] last_beat;

    function automatic logic [BEAT_W-1:0] last_of(input cmd_kind_e k);
        case (k)
            K_FILL:  return BEAT_W'(FILL_BEATS - 1);
            K_CTD:   return BEAT_W'(CTD_BEATS - 1);
            default: return '0;
        endcase
    endfunction

    assign free        = !active || (bus_beat == last_beat);
    assign bus_valid   = active;
    assign bus_virtual = active && (bus_kind == K_CTD);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            bus_kind  <= K_FILL;
            bus_beat  <= '0;
            last_beat <= '0;
            bus_addr  <= '0;
        end else if (start) begin
            active    <= 1'b1;
            bus_kind  <= start_kind;
            bus_beat  <= '0;
            last_beat <= last_of(start_kind);
            bus_addr  <= start_addr;
        end else if (active) begin
            if (bus_beat == last_beat) active <= 1'b0;
            else                       bus_beat <= bus_beat + 1'b1;
        end
    end

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst) (active && bus_beat != last_beat) |=> (active && bus_beat == $past(bus_beat) + 1'b1 && $stable(bus_kind))); // R2
    AST_NO_PROBE_KIND: assert property (@(posedge clk) disable iff (rst) start |-> (start_kind != K_PROBE)); // R2

endmodule

// File: rtl/coh_order_monitor.sv
module coh_order_monitor
    import coh_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int BLK_OFF = 6,
    parameter int BEAT_W  = 3,
    parameter int CNT_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pbus_valid,
    input  logic [1:0]        pbus_cycle,
    input  logic [ADDR_W-1:0] pbus_addr,
    input  logic              prb_resp,
    input  logic              dbus_valid,
    input  cmd_kind_e         dbus_kind,
    input  logic [BEAT_W-1:0] dbus_beat,
    input  logic [ADDR_W-1:0] dbus_addr,
    output logic              err
);

    logic [CNT_W-1:0]  seen_out;
    logic              fill_d1_due;
    logic [ADDR_W-1:0] fill_addr;

    function automatic logic same_blk(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
        return ((a ^ b) >> BLK_OFF) == '0;
    endfunction

    logic a0, a3, d0, d1, fillish, bad_resp, bad_fill, bad_rel;

    always_comb begin
        a0       = pbus_valid && pbus_cycle == 2'd0;
        a3       = pbus_valid && pbus_cycle == 2'd3;
        d0       = dbus_valid && dbus_beat == '0;
        d1       = dbus_valid && dbus_beat == BEAT_W'(1);
        fillish  = dbus_kind == K_FILL || dbus_kind == K_CTD;
        bad_resp = d0 && seen_out != '0;
        bad_fill = a3 && ((fill_d1_due && same_blk(pbus_addr, fill_addr) && !d1)
                       || (d0 && fillish && same_blk(pbus_addr, dbus_addr)));
        bad_rel  = a0 && dbus_valid && dbus_kind == K_REL && same_blk(pbus_addr, dbus_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_out    <= '0;
            fill_d1_due <= 1'b0;
            fill_addr   <= '0;
            err         <= 1'b0;
        end else begin
            seen_out <= seen_out + CNT_W'(a0) - CNT_W'(prb_resp && seen_out != '0);
            if (d0 && fillish) begin
                fill_d1_due <= 1'b1;
                fill_addr   <= dbus_addr;
            end else if (d1) begin
                fill_d1_due <= 1'b0;
            end
            err <= err || bad_resp || bad_fill || bad_rel;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err |=> err); // R10

endmodule

// File: rtl/coh_order_sched.sv
module coh_order_sched
    import coh_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int BLK_OFF     = 6,
    parameter int FILL_BEATS  = 8,
    parameter int CTD_BEATS   = 2,
    parameter int MAX_PRB_OUT = 2,
    localparam int MAXB       = (FILL_BEATS > CTD_BEATS) ? FILL_BEATS : CTD_BEATS,
    localparam int BEAT_W     = (MAXB > 2) ? $clog2(MAXB) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prb_req_valid,
    output logic              prb_req_ready,
    input  logic [ADDR_W-1:0] prb_req_addr,
    input  logic              fil_req_valid,
    output logic              fil_req_ready,
    input  logic [ADDR_W-1:0] fil_req_addr,
    input  logic              fil_req_ctd,
    input  logic              rel_req_valid,
    output logic              rel_req_ready,
    input  logic [ADDR_W-1:0] rel_req_addr,
    output logic              pbus_valid,
    output logic [1:0]        pbus_cycle,
    output logic [ADDR_W-1:0] pbus_addr,
    input  logic              prb_resp,
    output logic              dbus_valid,
    output logic [1:0]        dbus_kind,
    output logic [BEAT_W-1:0] dbus_beat,
    output logic              dbus_virtual,
    output logic [ADDR_W-1:0] dbus_addr,
    output logic              order_err
);

    localparam int CNT_W = $clog2(MAX_PRB_OUT + 1) + 1;
    localparam int IDX_W = $clog2(N_STREAMS);

    logic [N_STREAMS-1:0] in_v, in_rdy, acc, slot_v, take, in_ctd, slot_ctd;
    logic [ADDR_W-1:0]    in_addr  [N_STREAMS];
    logic [ADDR_W-1:0]    slot_addr[N_STREAMS];
    tag_t                 tag_in   [N_STREAMS];
    tag_t                 slot_tag [N_STREAMS];
    tag_t                 tag_base, tag_next;

    assign in_v    = {rel_req_valid, fil_req_valid, prb_req_valid};
    assign in_ctd  = {1'b0, fil_req_ctd, 1'b0};
    assign in_addr[S_PRB] = prb_req_addr;
    assign in_addr[S_FIL] = fil_req_addr;
    assign in_addr[S_REL] = rel_req_addr;
    assign prb_req_ready  = in_rdy[S_PRB];
    assign fil_req_ready  = in_rdy[S_FIL];
    assign rel_req_ready  = in_rdy[S_REL];
    assign acc            = in_v & in_rdy;

    // Same-edge arrivals take consecutive tags in stream index order
    always_comb begin
        tag_t run;
        run = tag_base;
        for (int i = 0; i < N_STREAMS; i++) begin
            tag_in[i] = run;
            if (acc[i]) run = run + 1'b1;
        end
        tag_next = run;
    end

    always_ff @(posedge clk) begin
        if (rst) tag_base <= '0;
        else     tag_base <= tag_next;
    end

    for (genvar g = 0; g < N_STREAMS; g++) begin : g_slot
        coh_req_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk(clk), .rst(rst),
            .in_valid(in_v[g]), .in_ready(in_rdy[g]),
            .in_addr(in_addr[g]), .in_ctd(in_ctd[g]), .in_tag(tag_in[g]),
            .take(take[g]),
            .out_valid(slot_v[g]), .out_addr(slot_addr[g]),
            .out_ctd(slot_ctd[g]), .out_tag(slot_tag[g])
        );
    end

    // Head of line: oldest pending request
    logic             head_v;
    logic [IDX_W-1:0] head_idx;
    cmd_kind_e        head_kind;
    logic             go, pe_free, de_free, prb_issue, data_issue;
    logic [CNT_W-1:0] prb_out;

    always_comb begin
        head_v   = 1'b0;
        head_idx = '0;
        for (int i = 0; i < N_STREAMS; i++) begin
            if (slot_v[i] && (!head_v || tag_older(slot_tag[i], slot_tag[head_idx]))) begin
                head_v   = 1'b1;
                head_idx = IDX_W'(i);
            end
        end
        if (head_idx == IDX_W'(S_PRB))      head_kind = K_PROBE;
        else if (head_idx == IDX_W'(S_FIL)) head_kind = slot_ctd[head_idx] ? K_CTD : K_FILL;
        else                                head_kind = K_REL;
        if (head_kind == K_PROBE) go = head_v && pe_free && (prb_out < CNT_W'(MAX_PRB_OUT));
        else                      go = head_v && de_free && (prb_out == '0);
        prb_issue  = go && head_kind == K_PROBE;
        data_issue = go && head_kind != K_PROBE;
        for (int i = 0; i < N_STREAMS; i++) take[i] = go && (head_idx == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) prb_out <= '0;
        else     prb_out <= prb_out + CNT_W'(prb_issue) - CNT_W'(prb_resp && prb_out != '0);
    end

    coh_probe_engine #(.ADDR_W(ADDR_W)) u_probe (
        .clk(clk), .rst(rst),
        .start(prb_issue), .start_addr(slot_addr[head_idx]), .free(pe_free),
        .bus_valid(pbus_valid), .bus_cycle(pbus_cycle), .bus_addr(pbus_addr)
    );

    cmd_kind_e dkind;

    coh_data_engine #(
        .ADDR_W(ADDR_W), .FILL_BEATS(FILL_BEATS), .CTD_BEATS(CTD_BEATS), .BEAT_W(BEAT_W)
    ) u_data (
        .clk(clk), .rst(rst),
        .start(data_issue), .start_kind(head_kind), .start_addr(slot_addr[head_idx]),
        .free(de_free),
        .bus_valid(dbus_valid), .bus_kind(dkind), .bus_beat(dbus_beat),
        .bus_virtual(dbus_virtual), .bus_addr(dbus_addr)
    );

    assign dbus_kind = dkind;

    coh_order_monitor #(
        .ADDR_W(ADDR_W), .BLK_OFF(BLK_OFF), .BEAT_W(BEAT_W), .CNT_W(CNT_W)
    ) u_mon (
        .clk(clk), .rst(rst),
        .pbus_valid(pbus_valid), .pbus_cycle(pbus_cycle), .pbus_addr(pbus_addr),
        .prb_resp(prb_resp),
        .dbus_valid(dbus_valid), .dbus_kind(dkind), .dbus_beat(dbus_beat),
        .dbus_addr(dbus_addr), .err(order_err)
    );

    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (rst) $onehot0(take)); // R3
    AST_DATA_AFTER_RESP: assert property (@(posedge clk) disable iff (rst) (dbus_valid && dbus_beat == '0) |-> (prb_out == '0)); // R5
    AST_PRB_CAP: assert property (@(posedge clk) disable iff (rst) prb_out <= CNT_W'(MAX_PRB_OUT)); // R11
    AST_NO_ORDER_ERR: assert property (@(posedge clk) disable iff (rst) !order_err); // R10

endmodule

// File: tb/coh_order_sched_bench.sv
`timescale 1ns/1ps
module coh_order_sched_bench;

    localparam int AW = 40;
    localparam int FB = 8;
    localparam int CB = 2;
    localparam int MP = 2;
    localparam int BW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prb_v = 0, fil_v = 0, fil_ctd = 0, rel_v = 0, prb_resp = 0;
    logic [AW-1:0] prb_a = '0, fil_a = '0, rel_a = '0;
    logic prb_rdy, fil_rdy, rel_rdy, pbus_valid, dbus_valid, dbus_virtual, order_err;
    logic [1:0] pbus_cycle, dbus_kind;
    logic [BW-1:0] dbus_beat;
    logic [AW-1:0] pbus_addr, dbus_addr;

    coh_order_sched #(.ADDR_W(AW), .BLK_OFF(6), .FILL_BEATS(FB), .CTD_BEATS(CB), .MAX_PRB_OUT(MP)) u_coh_order_sched (
        .clk(clk), .rst(rst),
        .prb_req_valid(prb_v), .prb_req_ready(prb_rdy), .prb_req_addr(prb_a),
        .fil_req_valid(fil_v), .fil_req_ready(fil_rdy), .fil_req_addr(fil_a), .fil_req_ctd(fil_ctd),
        .rel_req_valid(rel_v), .rel_req_ready(rel_rdy), .rel_req_addr(rel_a),
        .pbus_valid(pbus_valid), .pbus_cycle(pbus_cycle), .pbus_addr(pbus_addr),
        .prb_resp(prb_resp),
        .dbus_valid(dbus_valid), .dbus_kind(dbus_kind), .dbus_beat(dbus_beat),
        .dbus_virtual(dbus_virtual), .dbus_addr(dbus_addr), .order_err(order_err)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, fails = 0;
    int rdelay = 3;
    int ev_n = 0, dcnt = 0, last_a0 = 0;
    bit bad_seq = 0;
    int ev_kind[16];
    int ev_cyc[16];
    bit ev_virt[16];
    logic [AW-1:0] ev_addr[16];
    int due[8];
    bit due_v[8];

    // Bus observer and response generator, all at the falling edge
    always @(negedge clk) begin
        bit fire;
        fire = 0;
        if (!rst) begin
            if (pbus_valid) begin
                if (pbus_cycle == 2'd0) begin
                    last_a0 = cyc;
                    if (ev_n < 16) begin
                        ev_kind[ev_n] = 0; ev_cyc[ev_n] = cyc; ev_virt[ev_n] = 0; ev_addr[ev_n] = pbus_addr;
                        ev_n++;
                    end
                    for (int i = 0; i < 8; i++) if (!due_v[i]) begin due_v[i] = 1; due[i] = cyc + rdelay; break; end
                end else if (cyc - last_a0 != int'(pbus_cycle)) bad_seq = 1;
            end
            if (dbus_valid) begin
                dcnt++;
                if (dbus_beat == '0 && ev_n < 16) begin
                    ev_kind[ev_n] = int'(dbus_kind); ev_cyc[ev_n] = cyc; ev_virt[ev_n] = dbus_virtual; ev_addr[ev_n] = dbus_addr;
                    ev_n++;
                end
            end
            for (int i = 0; i < 8; i++) if (due_v[i] && due[i] == cyc + 1) begin due_v[i] = 0; fire = 1; end
        end
        prb_resp = fire;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nbeats(input int k);
        case (k) 0: return 0; 1: return FB; 2: return CB; default: return 1; endcase
    endfunction

    function automatic bit rdy(input int k);
        case (k) 0: return prb_rdy; 1, 2: return fil_rdy; default: return rel_rdy; endcase
    endfunction

    task automatic set_req(input int k, input logic [AW-1:0] a, input bit on);
        case (k)
            0: begin prb_v = on; prb_a = a; end
            1: begin fil_v = on; fil_a = a; fil_ctd = 0; end
            2: begin fil_v = on; fil_a = a; fil_ctd = 1; end
            default: begin rel_v = on; rel_a = a; end
        endcase
    endtask

    // Called just after a falling edge; returns the accepting edge number
    task automatic push(input int k, input logic [AW-1:0] a, output int acc);
        set_req(k, a, 1);
        while (!rdy(k)) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        set_req(k, a, 0);
    endtask

    task automatic begin_scn(input int r);
        @(negedge clk);
        rdelay = r; ev_n = 0; dcnt = 0; bad_seq = 0;
    endtask

    task automatic drain();
        repeat (45) @(negedge clk);
    endtask

    function automatic int exp_second(input int f, input int s, input int k, input int r);
        if (f == 0) return (s == 0) ? k + 5 : k + r + 2;
        if (f == 1) return (s == 0) ? k + 2 : k + 1 + FB;
        if (f == 2) return (s == 0) ? k + 2 : k + 1 + CB;
        return k + 2;
    endfunction

    task automatic run_tests();
        int k, k2, k3;
        logic [AW-1:0] a1, a2;
        // reset state
        check(prb_rdy && fil_rdy && rel_rdy, "R9 ready after reset", {prb_rdy, fil_rdy, rel_rdy}, 7);
        check(!pbus_valid && !dbus_valid, "R1 buses idle after reset", {pbus_valid, dbus_valid}, 0);
        check(!order_err, "R10 flag low after reset", order_err, 0);

        // each kind alone
        for (int kd = 0; kd < 4; kd++) begin
            begin_scn(3);
            a1 = AW'(40'h0000_4000 + kd * 40'h100 + 40'h18);
            push(kd, a1, k);
            drain();
            check(ev_n == 1 && ev_cyc[0] == k + 1, "R9 solo start cycle", ev_cyc[0], k + 1);
            check(ev_kind[0] == kd && ev_addr[0] == a1, "R2 solo kind and address", ev_kind[0], kd);
            check(dcnt == nbeats(kd), "R2 beat count", dcnt, nbeats(kd));
            check(ev_virt[0] == (kd == 2), "R2 virtual flag", ev_virt[0], kd == 2);
            check(!bad_seq, "R1 address phase sequence", bad_seq, 0);
        end

        // every ordered pair, same/different block, two response delays
        for (int f = 0; f < 4; f++)
            for (int s = 0; s < 4; s++)
                for (int sb = 0; sb < 2; sb++)
                    for (int ri = 0; ri < 2; ri++) begin
                        int r, e;
                        r = ri ? 7 : 3;
                        begin_scn(r);
                        a1 = AW'(40'h0010_0000 + (f * 16 + s * 4 + sb * 2 + ri) * 40'h400);
                        a2 = sb ? a1 + 40'h8 : a1 + 40'hC0;
                        push(f, a1, k);
                        push(s, a2, k2);
                        drain();
                        e = exp_second(f, s, k, r);
                        check(k2 == k + 1, "R9 second accepted next edge", k2, k + 1);
                        check(ev_n == 2 && ev_kind[0] == f && ev_cyc[0] == k + 1, "R3 first issued first", ev_kind[0], f);
                        if (f == 0 && s == 0)      check(ev_cyc[1] == e, "R4 probe after probe", ev_cyc[1], e);
                        else if (f == 0)           check(ev_cyc[1] == e, "R5 data after probe response", ev_cyc[1], e);
                        else if (s == 0 && f != 3) check(ev_cyc[1] == e, "R6 probe after fill", ev_cyc[1], e);
                        else if (s == 0)           check(ev_cyc[1] == e, "R7 probe after release", ev_cyc[1], e);
                        else                       check(ev_cyc[1] == e, "R8 data after data", ev_cyc[1], e);
                        check(ev_kind[1] == s && ev_addr[1] == a2, "R3 second kind and address", ev_kind[1], s);
                        check(dcnt == nbeats(f) + nbeats(s), "R2 total beats", dcnt, nbeats(f) + nbeats(s));
                        check(!order_err && !bad_seq, "R10 no violation flagged", order_err, 0);
                    end

        // all three streams accepted on one edge
        begin_scn(4);
        @(negedge clk);
        set_req(0, 40'h0020_0000, 1); set_req(1, 40'h0020_1000, 1); set_req(3, 40'h0020_2000, 1);
        k = cyc + 1;
        @(negedge clk);
        set_req(0, 40'h0, 0); set_req(1, 40'h0, 0); set_req(3, 40'h0, 0);
        drain();
        check(ev_n == 3 && ev_kind[0] == 0 && ev_cyc[0] == k + 1, "R3 tie: probe first", ev_cyc[0], k + 1);
        check(ev_kind[1] == 1 && ev_cyc[1] == k + 6, "R3 tie: fill after probe response", ev_cyc[1], k + 6);
        check(ev_kind[2] == 3 && ev_cyc[2] == k + 6 + FB, "R3 tie: release last", ev_cyc[2], k + 6 + FB);

        // third probe while two are unanswered
        begin_scn(12);
        push(0, 40'h0030_0000, k);
        push(0, 40'h0030_1000, k2);
        push(0, 40'h0030_2000, k3);
        drain();
        check(ev_n == 3 && ev_cyc[1] == k + 5, "R4 second probe back to back", ev_cyc[1], k + 5);
        check(ev_cyc[2] == k + 14, "R11 third probe waits for a response", ev_cyc[2], k + 14);
        check(!order_err, "R10 flag still low", order_err, 0);
    endtask

    initial begin
        bit timeout;
        timeout = 0;
        for (int i = 0; i < 8; i++) due_v[i] = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        fork
            run_tests();
            begin repeat (100000) @(posedge clk); timeout = 1; end
        join_any
        disable fork;
        if (timeout) check(0, "watchdog", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule